// File: doc/BRIEF.md
# Packed-Lane Funnel Shifter

This block takes a 128-bit vector pair and treats it as four 32-bit lanes or two 64-bit lanes, chosen per transaction. In every lane a high word and a low word are joined into a double-width value. That value is shifted left or right by the lane's own amount, and one lane-width word comes back. With a right shift the low half of the shifted value is kept. With a left shift the high half is kept.

The shift amount is handled in one of two ways. In wrap mode it is taken modulo the lane width. In clamp mode it saturates at the lane width. To get a rotate, drive the same data on both operands.

Transactions use a valid/ready handshake. With the default output register, a result is presented one cycle after it is accepted and is held while the consumer stalls. A parameter removes the register, which makes the unit purely combinational.

Top module: `simd_funnel_shifter`

## Requirements
- R1: With `shift_left`=0, each lane result is the low lane-width bits of {`src_hi` lane, `src_lo` lane} shifted right by the effective amount.
- R2: With `shift_left`=1, each lane result is the high lane-width bits of {`src_hi` lane, `src_lo` lane} shifted left by the effective amount.
- R3: With `clamp_mode`=0 the effective amount is the examined amount modulo the lane width. Bits of an amount field above the examined ones have no effect.
- R4: With `clamp_mode`=1 an examined amount at or above the lane width acts as exactly the lane width. In that case a right shift returns the `src_hi` lane and a left shift returns the `src_lo` lane.
- R5: An effective amount of zero returns the `src_lo` lane for right shifts and the `src_hi` lane for left shifts.
- R6: When both operands are equal, the result is that value rotated in the selected direction. In wrap mode a left rotate by N equals a right rotate by (width − N) mod width.
- R7: With `wide_lanes`=0, lane k occupies bits [32k+31:32k] and takes its amount from bits [32k+5:32k]. With `wide_lanes`=1, lane k occupies bits [64k+63:64k] and takes its amount from bits [64k+6:64k].
- R8: Each lane uses only its own operands and its own amount field.
- R9: `in_ready` equals (!`out_valid` || `out_ready`). An accepted input shows its result with `out_valid` on the following cycle. A stalled output keeps its value.
- R10: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can accept an input this cycle |
| wide_lanes | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| shift_left | input | 1 | 0: right funnel shift, 1: left funnel shift |
| clamp_mode | input | 1 | 0: wrap amount, 1: saturate amount at lane width |
| src_hi | input | 128 | Upper operand of each lane |
| src_lo | input | 128 | Lower operand of each lane |
| amt | input | 128 | Per-lane shift amount fields |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 128 | Per-lane funnel shift results |

## Verification
The bench sweeps the boundary amounts 0, width−1, width, width+1 and 2·width−1 over every combination of lane size, mode and direction. Comparing wrap against clamp at these amounts separates modulo reduction from saturation, and junk written above the examined bits shows whether too many amount bits are decoded. Vectors with a different random amount in every lane expose cross-lane leakage and a wrong choice of amount field. Rotate vectors, with equal operands, check the rotate results against an independently written rotate. A randomly stalled `out_ready` confirms that results are held and come out in order.

// File: rtl/simd_funnel_shifter.sv
module simd_funnel_shifter #(
  parameter int VEC_W        = 128,
  parameter int NARROW_W     = 32,
  parameter int WIDE_W       = 64,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             wide_lanes,
  input  logic             shift_left,
  input  logic             clamp_mode,
  input  logic [VEC_W-1:0] src_hi,
  input  logic [VEC_W-1:0] src_lo,
  input  logic [VEC_W-1:0] amt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] result
);

  localparam int N_NARROW = VEC_W / NARROW_W;
  localparam int N_WIDE   = VEC_W / WIDE_W;
  localparam int NB       = $clog2(NARROW_W) + 1;
  localparam int WB       = $clog2(WIDE_W) + 1;

  logic [VEC_W-1:0] narrow_res, wide_res, comb_res;

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    logic [NARROW_W-1:0]   a, b;
    logic [NB-1:0]         raw, sh;
    logic [2*NARROW_W-1:0] cat, rsh, lsh;
    assign a   = src_hi[NARROW_W*i +: NARROW_W];
    assign b   = src_lo[NARROW_W*i +: NARROW_W];
    assign raw = amt[NARROW_W*i +: NB];
    assign sh  = clamp_mode ? (raw[NB-1] ? NB'(NARROW_W) : raw)
                            : {1'b0, raw[NB-2:0]};
    assign cat = {a, b};
    assign rsh = cat >> sh;
    assign lsh = cat << sh;
    assign narrow_res[NARROW_W*i +: NARROW_W] =
      shift_left ? lsh[2*NARROW_W-1:NARROW_W] : rsh[NARROW_W-1:0];
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    logic [WIDE_W-1:0]   a, b;
    logic [WB-1:0]       raw, sh;
    logic [2*WIDE_W-1:0] cat, rsh, lsh;
    assign a   = src_hi[WIDE_W*j +: WIDE_W];
    assign b   = src_lo[WIDE_W*j +: WIDE_W];
    assign raw = amt[WIDE_W*j +: WB];
    assign sh  = clamp_mode ? (raw[WB-1] ? WB'(WIDE_W) : raw)
                            : {1'b0, raw[WB-2:0]};
    assign cat = {a, b};
    assign rsh = cat >> sh;
    assign lsh = cat << sh;
    assign wide_res[WIDE_W*j +: WIDE_W] =
      shift_left ? lsh[2*WIDE_W-1:WIDE_W] : rsh[WIDE_W-1:0];
  end

  assign comb_res = wide_lanes ? wide_res : narrow_res;

  if (REGISTER_OUT) begin : g_reg
    logic [VEC_W-1:0] res_q;
    logic             vld_q;
    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign result    = res_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= comb_res;
      end
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = comb_res;
  end

endmodule

module simd_funnel_shifter_chk #(
  parameter int VEC_W        = 128,
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             shift_left,
  input logic             clamp_mode,
  input logic [VEC_W-1:0] src_hi,
  input logic [VEC_W-1:0] src_lo,
  input logic [VEC_W-1:0] amt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] result
);

  logic take;
  assign take = in_valid && in_ready;

  if (REGISTER_OUT) begin : g_reg
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R10
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R9
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(result)); // R9
    AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      take && !shift_left && amt == '0 |=> result == $past(src_lo)); // R5
    AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      take && shift_left && amt == '0 |=> result == $past(src_hi)); // R5
    AST_CLAMP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      take && clamp_mode && !shift_left && &amt |=> result == $past(src_hi)); // R4
    AST_CLAMP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      take && clamp_mode && shift_left && &amt |=> result == $past(src_lo)); // R4
  end else begin : g_comb
    AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready && out_valid == in_valid); // R9
    AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !shift_left && amt == '0 |-> result == src_lo); // R5
    AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && shift_left && amt == '0 |-> result == src_hi); // R5
    AST_CLAMP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clamp_mode && !shift_left && &amt |-> result == src_hi); // R4
    AST_CLAMP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clamp_mode && shift_left && &amt |-> result == src_lo); // R4
  end

endmodule

bind simd_funnel_shifter simd_funnel_shifter_chk #(
  .VEC_W(VEC_W), .REGISTER_OUT(REGISTER_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .shift_left(shift_left), .clamp_mode(clamp_mode), .src_hi(src_hi),
  .src_lo(src_lo), .amt(amt), .out_valid(out_valid), .out_ready(out_ready),
  .result(result)
);

// File: tb/simd_funnel_shifter_tb.sv
`timescale 1ns/1ps
module simd_funnel_shifter_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         wide_lanes = 1'b0;
  logic         shift_left = 1'b0;
  logic         clamp_mode = 1'b0;
  logic [127:0] src_hi = '0;
  logic [127:0] src_lo = '0;
  logic [127:0] amt = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  string        cur_tag = "";
  bit           cur_rot = 1'b0;

  always #2 clk = ~clk;

  simd_funnel_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .wide_lanes(wide_lanes), .shift_left(shift_left), .clamp_mode(clamp_mode),
    .src_hi(src_hi), .src_lo(src_lo), .amt(amt), .out_valid(out_valid),
    .out_ready(out_ready), .result(result)
  );

  function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b, int w,
                                           bit left, bit clamp, logic [63:0] field);
    int ebits = (w == 32) ? 6 : 7;
    int raw   = int'(field & ((64'd1 << ebits) - 64'd1));
    int s;
    int idx;
    logic [63:0] r = '0;
    s = clamp ? ((raw >= w) ? w : raw) : (raw % w);
    for (int k = 0; k < w; k++) begin
      idx  = left ? (k + w - s) : (k + s);
      r[k] = (idx < w) ? b[idx] : a[idx - w];
    end
    return r;
  endfunction

  function automatic logic [63:0] rot_lane(logic [63:0] x, int w, bit left, logic [63:0] field);
    int ebits = (w == 32) ? 6 : 7;
    int n     = int'(field & ((64'd1 << ebits) - 64'd1)) % w;
    int s     = left ? ((w - n) % w) : n;
    logic [63:0] r = '0;
    for (int k = 0; k < w; k++) r[k] = x[(k + s) % w];
    return r;
  endfunction

  function automatic logic [127:0] model(bit wide, bit left, bit clamp, bit rot,
                                         logic [127:0] hi, logic [127:0] lo, logic [127:0] am);
    int w = wide ? 64 : 32;
    logic [63:0] mask = wide ? '1 : 64'h0000_0000_ffff_ffff;
    logic [127:0] res = '0;
    logic [63:0] a, b, f, r;
    for (int i = 0; i < 128 / w; i++) begin
      a = 64'(hi >> (i * w)) & mask;
      b = 64'(lo >> (i * w)) & mask;
      f = 64'(am >> (i * w)) & mask;
      r = rot ? rot_lane(a, w, left, f) : ref_lane(a, b, w, left, clamp, f);
      res = res | (128'(r & mask) << (i * w));
    end
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] make_amt(bit wide, int v, bit junk);
    int w = wide ? 64 : 32;
    int ebits = wide ? 7 : 6;
    logic [127:0] res = '0;
    logic [63:0] f;
    for (int i = 0; i < 128 / w; i++) begin
      f = 64'(v);
      if (junk) f = f | (({$urandom, $urandom} >> ebits) << ebits);
      if (!wide) f = f & 64'h0000_0000_ffff_ffff;
      res = res | (128'(f) << (i * w));
    end
    return res;
  endfunction

  task automatic step(output bit acc);
    logic [127:0] e;
    string t;
    #1;
    checks++;
    if (in_ready !== (!out_valid || out_ready)) begin
      errors++;
      $display("FAIL R9 in_ready actual=%b expected=%b", in_ready, !out_valid || out_ready);
    end
    acc = in_valid && in_ready;
    if (acc) begin
      exp_q.push_back(model(wide_lanes, shift_left, clamp_mode, cur_rot, src_hi, src_lo, amt));
      tag_q.push_back(cur_tag);
    end
    if (out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected result actual=%h expected=none", result);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (result !== e) begin
          errors++;
          $display("FAIL %s result actual=%h expected=%h", t, result, e);
        end
      end
    end
  endtask

  task automatic drive(bit wide, bit left, bit clamp, bit rot, logic [127:0] hi,
                       logic [127:0] lo, logic [127:0] am, string tag);
    bit acc;
    do begin
      @(negedge clk);
      in_valid = 1'b1; wide_lanes = wide; shift_left = left; clamp_mode = clamp;
      src_hi = hi; src_lo = lo; amt = am; cur_tag = tag; cur_rot = rot;
      out_ready = ($urandom % 4) != 0;
      step(acc);
    end while (!acc);
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      step(acc);
    end
  endtask

  initial begin
    logic [127:0] x;
    int w;
    int amts[5];
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 out_valid in reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    for (int wd = 0; wd < 2; wd++)
      for (int cl = 0; cl < 2; cl++)
        for (int lf = 0; lf < 2; lf++) begin
          w = wd ? 64 : 32;
          amts = '{0, w - 1, w, w + 1, 2 * w - 1};
          foreach (amts[k])
            for (int jk = 0; jk < 2; jk++)
              drive(wd[0], lf[0], cl[0], 1'b0, rnd128(), rnd128(),
                    make_amt(wd[0], amts[k], jk[0]),
                    {lf ? "R2" : "R1", cl ? " R4" : " R3", amts[k] == 0 ? " R5" : "", " R7"});
          if (cl) drive(wd[0], lf[0], 1'b1, 1'b0, rnd128(), rnd128(), '1, "R4 all-ones");
        end
    for (int n = 0; n < 40; n++)
      drive(n[0], n[1], n[2], 1'b0, rnd128(), rnd128(), rnd128(), "R8 R7 per-lane amounts");
    for (int n = 0; n < 30; n++) begin
      x = rnd128();
      drive(n[0], n[1], 1'b0, 1'b1, x, x, rnd128(), "R6 rotate");
    end
    for (int n = 1; n < 32; n += 5) begin
      x = rnd128();
      drive(1'b0, 1'b1, 1'b0, 1'b1, x, x, make_amt(1'b0, n, 1'b0), "R6 left N");
      drive(1'b0, 1'b0, 1'b0, 1'b1, x, x, make_amt(1'b0, 32 - n, 1'b0), "R6 right W-N");
    end
    idle(6);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing actual=%0d expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule